// File: doc/BRIEF.md
# LCD Controller Register Access Engine (SPI)

This block is an SPI master that performs register operations on a small LCD controller. Each operation is requested on a command port with a valid/ready handshake. The block builds the byte frames, drives the serial clock, the data output and an active-low chip select, and samples the returned serial data. A single-cycle done pulse marks the end of each command. For read commands, the 16-bit result is presented alongside that pulse.

Four operations exist:
- Set the register index.
- Write a 16-bit register (index frame, then data frame).
- Read a 16-bit register (index frame, then data frame).
- Read the status word in one long frame.

Every frame opens with a leading control byte. Its upper five bits are fixed. Its three low bits carry the controller ID, a target-select bit and a direction bit.

An optional inversion complements every transmitted bit. This covers boards whose data line passes through an inverter. The serial clock half-period is derived from the system clock frequency and a maximum serial rate. The serial rate therefore never exceeds the configured ceiling.

Top module: `lcd_spi_regeng`

## Requirements
- R1: The leading byte of every frame is {5'b01110, id, sel, dir}: bit 2 is the `cfg_id` value latched at acceptance, bit 1 (sel) is 0 for the index target and 1 for register data, bit 0 (dir) is 0 for write and 1 for read.
- R2: Command code 0 (index set) sends one 3-byte frame: leading byte (sel 0, dir 0), 0x00, then `cmd_reg`.
- R3: Command code 1 (register write) sends the R2 frame and then a second 3-byte frame: leading byte (sel 1, dir 0), `cmd_wdata[15:8]`, `cmd_wdata[7:0]`. The two frames are separate chip-select assertions.
- R4: Command code 2 (register read) sends the R2 frame and then a 3-byte frame: leading byte (sel 1, dir 1), 0x00, 0x00. `rdata` becomes {second received byte, third received byte} of that second frame.
- R5: Command code 3 (status read) sends one 4-byte frame: leading byte (sel 0, dir 1) and three 0x00 bytes. The second received byte is discarded and `rdata` becomes {third, fourth received byte}.
- R6: With `cfg_invert` at 1 on acceptance, every transmitted byte, including leading and filler bytes, is bitwise complemented. Received data is never complemented.
- R7: The serial format is SPI mode 0, MSB first: the data output changes only on falling serial clock edges and data in is sampled on rising edges. The serial clock is low whenever chip select is high. Between frames, chip select stays high for at least two serial clock periods.
- R8: Every serial clock phase lasts at least ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)) system cycles, so the serial rate never exceeds SCLK_MAX_HZ.
- R9: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `busy` is high from the next cycle through the done cycle, and `cmd_ready` equals not `busy`. Commands presented while busy are ignored.
- R10: `done` is high for exactly one cycle per command. `rdata` changes only in a done cycle of a command code 2 or 3, and holds its value across commands 0 and 1.
- R11: During and right after reset, chip select is high, the serial clock is low, `busy` and `done` are low, `cmd_ready` is high and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be accepted |
| cmd_op | input | 2 | Command code: 0 index, 1 write, 2 read, 3 status |
| cmd_reg | input | 8 | Register number |
| cmd_wdata | input | 16 | Write value |
| cfg_id | input | 1 | Controller ID bit (normally tied to 1) |
| cfg_invert | input | 1 | Complement all transmitted bytes |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read or status command |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the controller |

## Verification
Acceptance happens on the clock edge where valid meets ready. `busy` is due one cycle later, so the bench drops `cmd_valid` at the following falling edge and checks `busy` there. `done` and the new `rdata` are registered on the same edge, and `busy` falls one cycle after `done`. The bench therefore samples `rdata` in the falling-edge half of the done cycle, then checks `busy`, `done` and `cmd_ready` one falling edge later. Frame contents are captured by a serial slave model on the serial clock edges. The last chip-select release always comes at least a full inter-frame gap before `done`, so each frame comparison is made once `done` has been seen. Phase widths and chip-select gaps are measured in simulated time and compared against the derived minimum at the end of the run.

// File: rtl/lcdspi_pkg.sv
package lcdspi_pkg;

    localparam int BYTE_W     = 8;
    localparam int MAX_BYTES  = 4;
    localparam int FRAME_W    = MAX_BYTES * BYTE_W;
    localparam int NBYTE_W    = $clog2(MAX_BYTES + 1);
    localparam int WORD_W     = 16;

    typedef enum logic [1:0] {
        OP_INDEX  = 2'd0,
        OP_WRITE  = 2'd1,
        OP_READ   = 2'd2,
        OP_STATUS = 2'd3
    } op_e;

    // Leading control byte: fixed 01110 prefix, then id, target select, direction.
    function automatic logic [BYTE_W-1:0] lead_byte(input logic id, input logic sel,
                                                    input logic dir);
        return {5'b01110, id, sel, dir};
    endfunction

endpackage

// File: rtl/lcdspi_clkdiv.sv
module lcdspi_clkdiv #(
    parameter int HALF_DIV = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = cnt_q + CW'(1);
        if (!en || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lcdspi_frame.sv
module lcdspi_frame
    import lcdspi_pkg::*;
#(
    parameter int GAP_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [NBYTE_W-1:0] nbytes,
    input  logic               tick,
    input  logic               miso,
    output logic               active,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic [WORD_W-1:0]  rx_word,
    output logic               fdone
);
    localparam int BW = $clog2(FRAME_W + 1);
    localparam int GW = $clog2(GAP_TICKS + 1);

    typedef enum logic [1:0] {FS_IDLE, FS_SHIFT, FS_GAP} fstate_e;

    typedef struct packed {
        fstate_e            st;
        logic [FRAME_W-1:0] tx;
        logic [WORD_W-1:0]  rx;
        logic [BW-1:0]      left;
        logic [GW-1:0]      gap;
        logic               sclk;
        logic               cs_n;
        logic               fdone;
    } frame_regs_t;

    frame_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.fdone = 1'b0;
        unique case (r_q.st)
            FS_IDLE: begin
                if (start) begin
                    r_d.tx   = frame_in;
                    r_d.left = BW'(32'(nbytes) << 3);
                    r_d.sclk = 1'b0;
                    r_d.cs_n = 1'b0;
                    r_d.st   = FS_SHIFT;
                end
            end
            FS_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        r_d.rx   = {r_q.rx[WORD_W-2:0], miso};
                    end else begin
                        r_d.sclk = 1'b0;
                        r_d.tx   = {r_q.tx[FRAME_W-2:0], 1'b0};
                        r_d.left = r_q.left - BW'(1);
                        if (r_q.left == BW'(1)) begin
                            r_d.cs_n = 1'b1;
                            r_d.gap  = '0;
                            r_d.st   = FS_GAP;
                        end
                    end
                end
            end
            FS_GAP: begin
                if (tick) begin
                    if (r_q.gap == GW'(GAP_TICKS - 1)) begin
                        r_d.fdone = 1'b1;
                        r_d.st    = FS_IDLE;
                    end else begin
                        r_d.gap = r_q.gap + GW'(1);
                    end
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= FS_IDLE;
            r_q.tx    <= '0;
            r_q.rx    <= '0;
            r_q.left  <= '0;
            r_q.gap   <= '0;
            r_q.sclk  <= 1'b0;
            r_q.cs_n  <= 1'b1;
            r_q.fdone <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign active  = (r_q.st != FS_IDLE);
    assign sclk    = r_q.sclk;
    assign mosi    = r_q.tx[FRAME_W-1];
    assign cs_n    = r_q.cs_n;
    assign rx_word = r_q.rx;
    assign fdone   = r_q.fdone;
endmodule

// File: rtl/lcd_spi_regeng.sv
module lcd_spi_regeng
    import lcdspi_pkg::*;
#(
    parameter int SYS_CLK_HZ     = 50_000_000,
    parameter int SCLK_MAX_HZ    = 4_000_000,
    parameter int CS_GAP_PERIODS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    input  logic        cfg_id,
    input  logic        cfg_invert,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    input  logic        spi_miso
);
    localparam int HALF_DIV  = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int GAP_TICKS = 2 * CS_GAP_PERIODS;
    localparam int SEC_W     = 3 * BYTE_W;

    typedef enum logic [1:0] {ST_IDLE, ST_FA, ST_FB, ST_FIN} state_e;

    typedef struct packed {
        state_e             st;
        op_e                op;
        logic [SEC_W-1:0]   fb;
        logic [WORD_W-1:0]  rdata;
        logic               go;
        logic [FRAME_W-1:0] frm;
        logic [NBYTE_W-1:0] nby;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic              tick, f_active, f_done;
    logic [WORD_W-1:0] f_rx;

    logic [BYTE_W-1:0]  lead_a, lead_b;
    logic [FRAME_W-1:0] frame_a;
    logic [SEC_W-1:0]   frame_b;
    op_e                op_in;

    lcdspi_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (f_active),
        .tick (tick)
    );

    lcdspi_frame #(.GAP_TICKS(GAP_TICKS)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (r_q.go),
        .frame_in(r_q.frm),
        .nbytes  (r_q.nby),
        .tick    (tick),
        .miso    (spi_miso),
        .active  (f_active),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .rx_word (f_rx),
        .fdone   (f_done)
    );

    // Frame images built at acceptance from the command and the options.
    always_comb begin
        op_in  = op_e'(cmd_op);
        lead_a = lead_byte(cfg_id, 1'b0, op_in == OP_STATUS);
        lead_b = lead_byte(cfg_id, 1'b1, op_in == OP_READ);
        if (op_in == OP_STATUS) begin
            frame_a = {lead_a, 24'h000000};
        end else begin
            frame_a = {lead_a, 8'h00, cmd_reg, 8'h00};
        end
        frame_a = frame_a ^ {FRAME_W{cfg_invert}};
        if (op_in == OP_READ) begin
            frame_b = {lead_b, 16'h0000};
        end else begin
            frame_b = {lead_b, cmd_wdata};
        end
        frame_b = frame_b ^ {SEC_W{cfg_invert}};
    end

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.op  = op_in;
                    r_d.fb  = frame_b;
                    r_d.frm = frame_a;
                    r_d.nby = (op_in == OP_STATUS) ? NBYTE_W'(4) : NBYTE_W'(3);
                    r_d.go  = 1'b1;
                    r_d.st  = ST_FA;
                end
            end
            ST_FA: begin
                if (f_done) begin
                    if (r_q.op == OP_WRITE || r_q.op == OP_READ) begin
                        r_d.frm = {r_q.fb, 8'h00};
                        r_d.nby = NBYTE_W'(3);
                        r_d.go  = 1'b1;
                        r_d.st  = ST_FB;
                    end else begin
                        if (r_q.op == OP_STATUS) begin
                            r_d.rdata = f_rx;
                        end
                        r_d.st = ST_FIN;
                    end
                end
            end
            ST_FB: begin
                if (f_done) begin
                    if (r_q.op == OP_READ) begin
                        r_d.rdata = f_rx;
                    end
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.op    <= OP_INDEX;
            r_q.fb    <= '0;
            r_q.rdata <= '0;
            r_q.go    <= 1'b0;
            r_q.frm   <= '0;
            r_q.nby   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == ST_IDLE);
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_FIN);
    assign rdata     = r_q.rdata;
endmodule

// File: rtl/lcd_spi_regeng_chk.sv
module lcd_spi_regeng_chk #(
    parameter int HALF_DIV = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        spi_sclk,
    input logic        spi_cs_n
);
    logic [15:0] run_q;
    logic        sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 16'hFFFF;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= spi_sclk;
            if (spi_sclk != sclk_prev_q) begin
                run_q <= '0;
            end else if (run_q != 16'hFFFF) begin
                run_q <= run_q + 16'd1;
            end
        end
    end

    // R8: each serial clock phase spans at least HALF_DIV system cycles
    a_r8_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk != sclk_prev_q) |-> (run_q >= 16'(HALF_DIV - 1)));

    // R7: serial clock rests low while chip select is released
    a_r7_sclk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R7: no frame outside a command
    a_r7_cs_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    // R9: acceptance raises busy on the next cycle
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);

    // R9: busy holds until the done cycle
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R10: done is a single-cycle pulse inside busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10: read data only moves in a done cycle
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);
endmodule

bind lcd_spi_regeng lcd_spi_regeng_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n)
);

// File: tb/sim_lcd_spi_regeng.sv
`timescale 1ns/1ps
module sim_lcd_spi_regeng;
    localparam int SYS_HZ   = 50_000_000;
    localparam int MAX_HZ   = 4_000_000;
    localparam int HALF_MIN = (SYS_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);
    localparam int CLK_NS   = 20;
    localparam int NVEC     = 8;

    // {op, reg, wdata, id, invert, slave data}
    localparam logic [43:0] VEC [0:NVEC-1] = '{
        {2'd0, 8'h22, 16'h0000, 1'b1, 1'b0, 16'h0000},
        {2'd1, 8'h01, 16'h691B, 1'b1, 1'b0, 16'h0000},
        {2'd2, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h9221},
        {2'd3, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h1A2B},
        {2'd1, 8'h10, 16'h4240, 1'b0, 1'b1, 16'h0000},
        {2'd2, 8'h45, 16'h0000, 1'b0, 1'b1, 16'hDB00},
        {2'd3, 8'h00, 16'h0000, 1'b1, 1'b1, 16'h0F0F},
        {2'd1, 8'hFF, 16'hFFFF, 1'b0, 1'b0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_reg = 8'h00;
    logic [15:0] cmd_wdata = 16'h0000;
    logic        cfg_id = 1'b1;
    logic        cfg_invert = 1'b0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int failures = 0;

    always #(CLK_NS / 2) clk = ~clk;

    lcd_spi_regeng #(.SYS_CLK_HZ(SYS_HZ), .SCLK_MAX_HZ(MAX_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cfg_id(cfg_id),
        .cfg_invert(cfg_invert), .busy(busy), .done(done), .rdata(rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_miso(spi_miso)
    );

    // Serial slave model
    logic [31:0] resp_word = 32'h5AA5C33C;
    logic [31:0] cap = '0;
    int          bitn = 0;
    int          nf = 0;
    bit          in_frame = 1'b0;
    bit          have_rise = 1'b0;
    logic [31:0] rec_word [0:7];
    int          rec_bits [0:7];
    time         t_edge = 0, t_rise = 0;
    time         min_half = 1000000, min_gap = 1000000;

    always @(negedge spi_cs_n) begin
        in_frame = 1'b1;
        bitn = 0;
        cap = '0;
        spi_miso = resp_word[31];
        t_edge = $time;
        if (have_rise && ($time - t_rise) < min_gap) min_gap = $time - t_rise;
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            cap = {cap[30:0], spi_mosi};
            bitn++;
            if (($time - t_edge) < min_half) min_half = $time - t_edge;
            t_edge = $time;
        end
    end

    always @(negedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            if (bitn < 32) spi_miso = resp_word[31 - bitn];
            if (($time - t_edge) < min_half) min_half = $time - t_edge;
            t_edge = $time;
        end
    end

    always @(posedge spi_cs_n) begin
        if (in_frame) begin
            if (nf < 8) begin
                rec_word[nf] = cap;
                rec_bits[nf] = bitn;
            end
            nf++;
            in_frame = 1'b0;
            t_rise = $time;
            have_rise = 1'b1;
            spi_miso = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lead(input logic id, input logic sel, input logic dir);
        return 8'h70 | {5'b0, id, 2'b0} | {6'b0, sel, 1'b0} | {7'b0, dir};
    endfunction

    logic [15:0] last_rd = 16'h0000;

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] rg, input logic [15:0] wd,
                           input logic id, input logic inv, input logic [15:0] sdata,
                           input bit inject);
        int          base;
        int          w;
        bit          busy_ok;
        int          exp_nf;
        logic [31:0] ea, eb;
        int          ea_bits;
        logic [15:0] exp_rd;
        busy_ok = 1'b1;
        if (op == 2'd2) resp_word = {8'h3C, sdata, 8'h00};
        else if (op == 2'd3) resp_word = {8'h3C, 8'hE7, sdata};
        else resp_word = 32'h5AA5C33C;
        base = nf;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = rg; cmd_wdata = wd;
        cfg_id = id; cfg_invert = inv;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy && !cmd_ready, "R9 busy after accept", {30'b0, busy, cmd_ready}, 32'h2);
        w = 0;
        while (!done && w < 4000) begin
            if (inject && w == 3) begin
                cmd_valid = 1'b1; cmd_op = 2'd0; cmd_reg = 8'hEE;
            end
            if (inject && w == 12) cmd_valid = 1'b0;
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            w++;
        end
        chk(w < 4000, "R10 done arrives", w, 4000);
        chk(busy_ok && busy, "R9 busy held to done", {31'b0, busy_ok}, 32'h1);
        exp_rd = (op >= 2'd2) ? sdata : last_rd;
        chk(rdata == exp_rd, (op == 2'd3) ? "R5 status data" :
                             (op == 2'd2) ? "R4 read data" : "R10 rdata hold",
            {16'b0, rdata}, {16'b0, exp_rd});
        last_rd = exp_rd;
        @(negedge clk);
        chk(!done && !busy && cmd_ready, "R10 single done, R9 ready",
            {29'b0, done, busy, cmd_ready}, 32'h1);
        // expected frames
        exp_nf = (op == 2'd1 || op == 2'd2) ? 2 : 1;
        chk((nf - base) == exp_nf, "R3 frame count", nf - base, exp_nf);
        if (op == 2'd3) begin
            ea = {lead(id, 1'b0, 1'b1), 24'h0} ^ {32{inv}};
            ea_bits = 32;
        end else begin
            ea = {8'h00, lead(id, 1'b0, 1'b0), 8'h00, rg} ^ {8'h00, {24{inv}}};
            ea_bits = 24;
        end
        if (op == 2'd2) eb = {8'h00, lead(id, 1'b1, 1'b1), 16'h0} ^ {8'h00, {24{inv}}};
        else eb = {8'h00, lead(id, 1'b1, 1'b0), wd} ^ {8'h00, {24{inv}}};
        if ((nf - base) == exp_nf && base < 7) begin
            chk(rec_bits[base] == ea_bits, "R2 first frame length", rec_bits[base], ea_bits);
            chk(rec_word[base] == ea, inv ? "R6 R1 first frame bytes" : "R1 R2 first frame bytes",
                rec_word[base], ea);
            if (exp_nf == 2) begin
                chk(rec_bits[base + 1] == 24, "R3 second frame length", rec_bits[base + 1], 24);
                chk(rec_word[base + 1] == eb, inv ? "R6 R4 second frame bytes" : "R3 R4 second frame bytes",
                    rec_word[base + 1], eb);
            end
        end
        nf = 0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(spi_cs_n && !spi_sclk && !busy && !done && cmd_ready && rdata == 16'h0,
            "R11 in reset", {26'b0, spi_cs_n, spi_sclk, busy, done, cmd_ready, |rdata}, 32'h22);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n && !spi_sclk && !busy && !done && cmd_ready && rdata == 16'h0,
            "R11 after reset", {26'b0, spi_cs_n, spi_sclk, busy, done, cmd_ready, |rdata}, 32'h22);
        nf = 0;
        for (int i = 0; i < NVEC; i++) begin
            run_cmd(VEC[i][43:42], VEC[i][41:34], VEC[i][33:18], VEC[i][17], VEC[i][16],
                    VEC[i][15:0], 1'b0);
        end
        // R9: commands presented while busy are ignored
        run_cmd(2'd2, 8'h07, 16'h0000, 1'b1, 1'b0, 16'hC0DE, 1'b1);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (k == 59) chk(nf == 0 && spi_cs_n && !busy, "R9 busy command ignored",
                             nf, 0);
        end
        // R10: write after read keeps rdata
        run_cmd(2'd0, 8'h3A, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0);
        // R8: phase width at least HALF_MIN system cycles
        chk(min_half >= HALF_MIN * CLK_NS, "R8 phase width", 32'(min_half), HALF_MIN * CLK_NS);
        // R7: chip select gap at least two serial periods
        chk(min_gap >= 4 * HALF_MIN * CLK_NS, "R7 cs gap", 32'(min_gap), 4 * HALF_MIN * CLK_NS);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule